// File: doc/BRIEF.md
# Power and Lamp Enable Sequencer

This controller brings up a projector-style power domain and its lamp from an already debounced power key. The key has to be held without a break for a set number of clock cycles before anything happens. Once that hold completes, the block raises the power-on enable, but only when the supply-good flag reports every DC rail within specification. It then keeps the active-low reset asserted for a settling interval and releases it. In the same cycle it requests lamp ignition. After that it waits for the lamp-lit feedback.

An abnormal-status input forces the lamp enable low in the same cycle. It also latches the block into a fault state. The block also enters the fault state when the lamp does not light within a timeout, or when the lamp goes dark while running. While in the fault state, the alert LED blinks. A second full key hold while powered shuts the unit down in a fixed order: the lamp first, then reset, then power.

The hold length, the settling step, the ignition timeout and the blink half-period are parameters counted in clock cycles. Simulation can therefore use short values.

Top module: `pwr_lamp_seq`

## Requirements
- R1: With suppliesGood high, powerOn rises at the clock edge on which keyPressed has been sampled high for HOLD_CYCLES consecutive edges, and not before.
- R2: A hold shorter than HOLD_CYCLES edges has no effect: releasing the key clears the count, so two short holds never add up, and powerOn stays low.
- R3: powerOn rises only on an edge where suppliesGood is sampled high; if the hold completes while suppliesGood is low, powerOn stays low and rises on the first edge where suppliesGood is high.
- R4: resetN is low whenever powerOn is low; after powerOn rises it stays low for STEP_CYCLES edges and then goes high.
- R5: lampEnable goes high in the cycle resetN is released; when lampLit is seen, the unit runs with lampEnable high and ledPower steadily on.
- R6: faultIn high forces lampEnable low in the same cycle and latches a fault. lampEnable stays low after faultIn clears. ledAlert is on for BLINK_HALF cycles, then off for BLINK_HALF cycles, starting on in the first fault cycle, and ledPower stays on.
- R7: If lampLit is not seen within IGNITE_TIMEOUT edges of lampEnable rising, lampEnable drops at that edge and the fault state is entered.
- R8: If lampLit falls while the lamp is running, the block enters the fault state on the next edge and lampEnable drops.
- R9: A full key hold while powered drops lampEnable at the hold's final edge. resetN drops STEP_CYCLES edges later, and powerOn drops a further STEP_CYCLES edges after that.
- R10: During and right after reset, powerOn, resetN, lampEnable, ledPower and ledAlert are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low block reset |
| keyPressed | input | 1 | Debounced power key, high while held |
| suppliesGood | input | 1 | High when every DC supply is within specification |
| lampLit | input | 1 | Lamp feedback, high while the lamp is burning |
| faultIn | input | 1 | Abnormal-status flag |
| powerOn | output | 1 | Power domain enable |
| resetN | output | 1 | Active-low reset to the powered domain |
| lampEnable | output | 1 | Lamp ignition request to the ballast |
| ledPower | output | 1 | Power LED: blinks in transitions, steady when running or faulted |
| ledAlert | output | 1 | Alert LED: blinks in the fault state |

## Verification
On every cycle, the assertions check the following relations:
- powerOn only rises on the edge after suppliesGood was seen high.
- resetN is never released while powerOn is low.
- lampEnable is never high while faultIn is high or while the domain is in reset.
- The shutdown ordering holds between lamp, reset and power.

The bench scenarios show the behaviour that depends on counted intervals:
- the exact edge on which a hold completes, and the fact that interrupted holds do not accumulate;
- the settling step and the ignition timeout;
- the latching of the fault state and the blink phase;
- the spacing of the shutdown steps.

// File: rtl/pwr_lamp_seq_pkg.sv
package pwr_lamp_seq_pkg;

  typedef enum logic [2:0] {
    SeqOff,
    SeqArmed,
    SeqPower,
    SeqIgnite,
    SeqLampOn,
    SeqFault,
    SeqDownLamp,
    SeqDownReset
  } seq_state_e;

  // Control to datapath strobes
  typedef struct packed {
    logic timerClear;
    logic blinkRun;
  } ctrl_strobe_t;

  // Datapath to control status
  typedef struct packed {
    logic holdDone;
    logic stepDone;
    logic igniteExpired;
    logic blinkPhase;
  } dp_status_t;

endpackage

// File: rtl/pwr_lamp_seq_dp.sv
module pwr_lamp_seq_dp
  import pwr_lamp_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES    = 750_000_000,
  parameter int unsigned STEP_CYCLES    = 250_000,
  parameter int unsigned IGNITE_TIMEOUT = 250_000_000,
  parameter int unsigned BLINK_HALF     = 62_500_000
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         keyPressed,
  input  ctrl_strobe_t strobe,
  output dp_status_t   status
);

  localparam int unsigned HoldW = $clog2(HOLD_CYCLES + 1);
  localparam int unsigned TimerMax = (STEP_CYCLES > IGNITE_TIMEOUT) ? STEP_CYCLES : IGNITE_TIMEOUT;
  localparam int unsigned TimerW = $clog2(TimerMax + 1);

  logic [HoldW-1:0]  holdCnt;
  logic [TimerW-1:0] timer;
  logic              blinkPhase;

  // Hold counter: cleared by any break, saturates so one press fires once
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (!keyPressed) begin
      holdCnt <= '0;
    end else if (holdCnt != HoldW'(HOLD_CYCLES)) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  // Shared interval timer, restarted on every state change
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      timer <= '0;
    end else if (strobe.timerClear) begin
      timer <= '0;
    end else if (timer != TimerW'(TimerMax)) begin
      timer <= timer + 1'b1;
    end
  end

  // Blink generator; variant picked by the half period
  generate
    if (BLINK_HALF <= 1) begin : g_blink_fast
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          blinkPhase <= 1'b1;
        end else if (!strobe.blinkRun || strobe.timerClear) begin
          blinkPhase <= 1'b1;
        end else begin
          blinkPhase <= ~blinkPhase;
        end
      end
    end else begin : g_blink_count
      localparam int unsigned BlinkW = $clog2(BLINK_HALF);
      logic [BlinkW-1:0] blinkCnt;
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          blinkCnt   <= '0;
          blinkPhase <= 1'b1;
        end else if (!strobe.blinkRun || strobe.timerClear) begin
          blinkCnt   <= '0;
          blinkPhase <= 1'b1;
        end else if (blinkCnt == BlinkW'(BLINK_HALF - 1)) begin
          blinkCnt   <= '0;
          blinkPhase <= ~blinkPhase;
        end else begin
          blinkCnt <= blinkCnt + 1'b1;
        end
      end
    end
  endgenerate

  always_comb begin
    status.holdDone      = keyPressed && (holdCnt == HoldW'(HOLD_CYCLES - 1));
    status.stepDone      = (timer >= TimerW'(STEP_CYCLES - 1));
    status.igniteExpired = (timer >= TimerW'(IGNITE_TIMEOUT - 1));
    status.blinkPhase    = blinkPhase;
  end

  // R1: a completed hold implies the key was already down on the edge before
  assert_hold_continuous_R1: assert property (@(posedge clk) disable iff (!rstN)
    (status.holdDone && HOLD_CYCLES > 1) |-> $past(keyPressed));

  // R2: a released key leaves no partial count behind
  assert_break_clears_R2: assert property (@(posedge clk) disable iff (!rstN)
    !keyPressed |=> (holdCnt == '0));

endmodule

// File: rtl/pwr_lamp_seq_ctrl.sv
module pwr_lamp_seq_ctrl
  import pwr_lamp_seq_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         suppliesGood,
  input  logic         lampLit,
  input  logic         faultIn,
  input  dp_status_t   status,
  output ctrl_strobe_t strobe,
  output logic         powerOn,
  output logic         resetN,
  output logic         lampEnable,
  output logic         ledPower,
  output logic         ledAlert
);

  seq_state_e state, nextState;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= SeqOff;
    end else begin
      state <= nextState;
    end
  end

  always_comb begin
    nextState = state;
    unique case (state)
      SeqOff: begin
        if (status.holdDone) nextState = suppliesGood ? SeqPower : SeqArmed;
      end
      SeqArmed: begin
        if (suppliesGood)         nextState = SeqPower;
        else if (status.holdDone) nextState = SeqOff;
      end
      SeqPower: begin
        if (status.stepDone && suppliesGood) nextState = SeqIgnite;
      end
      SeqIgnite: begin
        if (faultIn)                   nextState = SeqFault;
        else if (lampLit)              nextState = SeqLampOn;
        else if (status.igniteExpired) nextState = SeqFault;
        else if (status.holdDone)      nextState = SeqDownLamp;
      end
      SeqLampOn: begin
        if (faultIn || !lampLit)  nextState = SeqFault;
        else if (status.holdDone) nextState = SeqDownLamp;
      end
      SeqFault: begin
        if (status.holdDone) nextState = SeqDownLamp;
      end
      SeqDownLamp: begin
        if (status.stepDone) nextState = SeqDownReset;
      end
      SeqDownReset: begin
        if (status.stepDone) nextState = SeqOff;
      end
      default: nextState = SeqOff;
    endcase
  end

  always_comb begin
    strobe.timerClear = (nextState != state);
    strobe.blinkRun   = !(state inside {SeqOff, SeqArmed, SeqLampOn});

    powerOn    = !(state inside {SeqOff, SeqArmed});
    resetN     = state inside {SeqIgnite, SeqLampOn, SeqFault, SeqDownLamp};
    lampEnable = (state inside {SeqIgnite, SeqLampOn}) && !faultIn;

    if (state inside {SeqLampOn, SeqFault}) begin
      ledPower = 1'b1;
    end else if (powerOn) begin
      ledPower = status.blinkPhase;
    end else begin
      ledPower = 1'b0;
    end
    ledAlert = (state == SeqFault) && status.blinkPhase;
  end

  // R3: power only comes up after supplies were reported good
  assert_power_needs_supplies_R3: assert property (@(posedge clk) disable iff (!rstN)
    $rose(powerOn) |-> $past(suppliesGood));

  // R4: reset is held while the domain is unpowered
  assert_reset_needs_power_R4: assert property (@(posedge clk) disable iff (!rstN)
    !powerOn |-> !resetN);

  // R5: ignition only with the domain powered and out of reset
  assert_lamp_needs_reset_R5: assert property (@(posedge clk) disable iff (!rstN)
    lampEnable |-> (resetN && powerOn));

  // R6: abnormal status blocks ignition in the same cycle
  assert_fault_blocks_lamp_R6: assert property (@(posedge clk) disable iff (!rstN)
    faultIn |-> !lampEnable);

  // R9: reset drops only after the lamp request was already gone
  assert_reset_after_lamp_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(resetN) |-> $past(!lampEnable));

  // R9: power drops only after reset was already asserted
  assert_power_after_reset_R9: assert property (@(posedge clk) disable iff (!rstN)
    $fell(powerOn) |-> $past(!resetN && !lampEnable));

endmodule

// File: rtl/pwr_lamp_seq.sv
module pwr_lamp_seq
  import pwr_lamp_seq_pkg::*;
#(
  parameter int unsigned HOLD_CYCLES    = 750_000_000,
  parameter int unsigned STEP_CYCLES    = 250_000,
  parameter int unsigned IGNITE_TIMEOUT = 250_000_000,
  parameter int unsigned BLINK_HALF     = 62_500_000
) (
  input  logic clk,
  input  logic rstN,
  input  logic keyPressed,
  input  logic suppliesGood,
  input  logic lampLit,
  input  logic faultIn,
  output logic powerOn,
  output logic resetN,
  output logic lampEnable,
  output logic ledPower,
  output logic ledAlert
);

  ctrl_strobe_t strobe;
  dp_status_t   status;

  pwr_lamp_seq_dp #(
    .HOLD_CYCLES   (HOLD_CYCLES),
    .STEP_CYCLES   (STEP_CYCLES),
    .IGNITE_TIMEOUT(IGNITE_TIMEOUT),
    .BLINK_HALF    (BLINK_HALF)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .keyPressed(keyPressed),
    .strobe    (strobe),
    .status    (status)
  );

  pwr_lamp_seq_ctrl u_ctrl (
    .clk         (clk),
    .rstN        (rstN),
    .suppliesGood(suppliesGood),
    .lampLit     (lampLit),
    .faultIn     (faultIn),
    .status      (status),
    .strobe      (strobe),
    .powerOn     (powerOn),
    .resetN      (resetN),
    .lampEnable  (lampEnable),
    .ledPower    (ledPower),
    .ledAlert    (ledAlert)
  );

endmodule

// File: tb/pwr_lamp_seq_test.sv
`timescale 1ns/1ps
module pwr_lamp_seq_test;

  localparam int unsigned HOLD  = 16;
  localparam int unsigned STEP  = 5;
  localparam int unsigned TOUT  = 40;
  localparam int unsigned BLINK = 3;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic keyPressed = 1'b0;
  logic suppliesGood = 1'b0;
  logic lampLit = 1'b0;
  logic faultIn = 1'b0;
  logic powerOn, resetN, lampEnable, ledPower, ledAlert;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;

  pwr_lamp_seq #(
    .HOLD_CYCLES(HOLD), .STEP_CYCLES(STEP),
    .IGNITE_TIMEOUT(TOUT), .BLINK_HALF(BLINK)
  ) uut (
    .clk(clk), .rstN(rstN), .keyPressed(keyPressed), .suppliesGood(suppliesGood),
    .lampLit(lampLit), .faultIn(faultIn), .powerOn(powerOn), .resetN(resetN),
    .lampEnable(lampEnable), .ledPower(ledPower), .ledAlert(ledAlert)
  );

  function automatic logic expTrigger(int unsigned len);
    return len >= HOLD;
  endfunction

  function automatic logic expBlink(int unsigned cyclesInFault);
    return ((cyclesInFault / BLINK) % 2) == 0;
  endfunction

  task automatic check(string req, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic ticks(int unsigned n);
    repeat (n) @(negedge clk);
  endtask

  // key high for exactly n rising edges, released at the following negedge
  task automatic holdKey(int unsigned n);
    keyPressed = 1'b1;
    ticks(n);
    keyPressed = 1'b0;
  endtask

  task automatic bringUp();
    suppliesGood = 1'b1;
    holdKey(HOLD);
    ticks(STEP);
    lampLit = 1'b1;
    ticks(1);
  endtask

  task automatic shutDown();
    holdKey(HOLD);
    ticks(2 * STEP);
    lampLit = 1'b0;
    ticks(1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    ticks(3);
    // R10: reset state
    check("R10 powerOn", powerOn, 1'b0);
    check("R10 resetN", resetN, 1'b0);
    check("R10 lampEnable", lampEnable, 1'b0);
    check("R10 leds", ledPower | ledAlert, 1'b0);
    rstN = 1'b1;
    ticks(2);
    check("R10 after release", powerOn | resetN | lampEnable, 1'b0);

    // R2: random short holds with supplies good never power up
    suppliesGood = 1'b1;
    for (int i = 0; i < 20; i++) begin
      int unsigned len;
      len = 1 + ($urandom % (HOLD - 1));
      holdKey(len);
      ticks(1 + ($urandom % 4));
      check("R2 short hold", powerOn, expTrigger(len));
    end
    holdKey(HOLD - 1);
    ticks(1);
    holdKey(HOLD - 1);
    ticks(1);
    check("R2 split holds do not add", powerOn, 1'b0);

    // R1: exact completion edge
    keyPressed = 1'b1;
    ticks(HOLD - 1);
    check("R1 one edge early", powerOn, 1'b0);
    ticks(1);
    check("R1 hold complete", powerOn, 1'b1);
    keyPressed = 1'b0;
    check("R4 reset held after power", resetN, 1'b0);
    ticks(STEP - 1);
    check("R4 reset before step", resetN, 1'b0);
    ticks(1);
    check("R4 reset released", resetN, 1'b1);
    check("R5 lamp requested with reset", lampEnable, 1'b1);
    ticks(3);
    lampLit = 1'b1;
    ticks(1);
    check("R5 running lamp", lampEnable, 1'b1);
    check("R5 power led steady", ledPower, 1'b1);
    ticks(4);
    check("R5 power led still steady", ledPower, 1'b1);

    // R9: shutdown ordering
    holdKey(HOLD);
    check("R9 lamp off first", lampEnable, 1'b0);
    check("R9 reset still up", resetN, 1'b1);
    ticks(STEP);
    check("R9 reset down", resetN, 1'b0);
    check("R9 power still up", powerOn, 1'b1);
    ticks(STEP - 1);
    check("R9 power before final step", powerOn, 1'b1);
    ticks(1);
    check("R9 power down", powerOn, 1'b0);
    lampLit = 1'b0;
    ticks(2);

    // R3: hold completes while supplies are bad
    suppliesGood = 1'b0;
    holdKey(HOLD);
    begin
      int unsigned waitCycles;
      waitCycles = 1 + ($urandom % 10);
      ticks(waitCycles);
      check("R3 waits for supplies", powerOn, 1'b0);
    end
    suppliesGood = 1'b1;
    ticks(1);
    check("R3 power after supplies good", powerOn, 1'b1);

    // R7: ignition timeout and R6 blink
    ticks(STEP);
    check("R7 lamp requested", lampEnable, 1'b1);
    ticks(TOUT - 1);
    check("R7 before timeout", lampEnable, 1'b1);
    ticks(1);
    check("R7 timeout drops lamp", lampEnable, 1'b0);
    for (int k = 0; k < 4 * BLINK; k++) begin
      check("R6 alert blink", ledAlert, expBlink(k));
      ticks(1);
    end
    check("R6 power led on in fault", ledPower, 1'b1);
    shutDown();
    check("R9 off after fault shutdown", powerOn | resetN, 1'b0);

    // R6: abnormal status while running
    bringUp();
    check("R6 running before fault", lampEnable, 1'b1);
    faultIn = 1'b1;
    #1;
    check("R6 same-cycle lamp block", lampEnable, 1'b0);
    ticks(1);
    faultIn = 1'b0;
    ticks(2);
    check("R6 fault latched", lampEnable, 1'b0);
    check("R6 still powered", resetN & powerOn, 1'b1);
    shutDown();

    // R8: lamp goes dark while running
    bringUp();
    lampLit = 1'b0;
    ticks(1);
    check("R8 lamp loss fault", lampEnable, 1'b0);
    check("R8 alert lit", ledAlert, 1'b1);
    shutDown();
    check("R8 down after shutdown", powerOn, 1'b0);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

endmodule